// File: doc/BRIEF.md
# Serial Converter Frame Master

This block is the host side of a serial link to a data converter whose frame length is not fixed. The converter expects a number of serial clock pulses equal to the length of its output word. That length depends on the resolution and sign setting chosen in the frame before the current one. The block keeps its own copy of the committed output format, so it always knows how many pulses the converter expects. It then issues exactly that many pulses on SCLK.

A request arrives on a valid/ready handshake. It carries an instruction byte, a resolution code, a sign flag, a bit-order flag, a chip-select mode and an "instruction only" flag. The block lowers CS, shifts the instruction out on DI (most significant bit first), and samples DO. It reassembles the word in the committed bit order and extends it to a 17-bit signed result, then pulses a done strobe. With CS strobed, the block raises CS between frames, and an instruction-only frame is cut to one instruction byte. With CS held low, every frame is full length and CS never rises.

Top module: `sadc_frame_master`

## Requirements
- R1: After reset, `exp_len` is 13 (12-bit resolution with sign), `cs_n` is 1, `sclk` is 0, `req_ready` is 1 and `result_valid` is 0.
- R2: Resolution codes are 0 for 8 bits, 1 for 12 bits and 2 for 16 bits; code 3 is treated as 12 bits. The frame length is that width plus one when sign is on, which gives 8, 9, 12, 13, 16 or 17.
- R3: The resolution, sign and bit order carried by a request are committed when that frame ends. The frame itself runs with the previously committed values, and `exp_len` does not change while a frame is active.
- R4: With `req_cs_strobed` = 0, a frame issues exactly `exp_len` SCLK pulses, even when it is instruction only. `cs_n` remains 0 after the frame ends.
- R5: With `req_cs_strobed` = 1 and `req_instr_only` = 1, a frame issues exactly 8 pulses. Any instruction-only frame leaves the committed format and `result` unchanged.
- R6: With CS strobed, `cs_n` rises when the frame ends and stays high, with `req_ready` low, for at least one SCLK period (2·`SCLK_HALF` clocks).
- R7: DI presents `req_instr` most significant bit first, one bit per SCLK pulse, and changes only when SCLK falls. Zeros follow once all eight bits are out.
- R8: DO is sampled as SCLK rises. Under the committed order, bit-order flag 0 means the first bit is the most significant of the word, and flag 1 means the first bit is bit 0.
- R9: When the committed sign flag is 1, `result` is the word sign-extended from its top bit to 17 bits. When the flag is 0, the word is zero-extended.
- R10: `result_valid` is a one-cycle pulse at the end of each frame, and `req_ready` is low while a frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (models power-up) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_instr | input | IW | Instruction byte for DI |
| req_res | input | 2 | Resolution code for following frames |
| req_sign | input | 1 | Sign bit on for following frames |
| req_lsb_first | input | 1 | Bit order for following frames |
| req_cs_strobed | input | 1 | 1: raise CS between frames |
| req_instr_only | input | 1 | Frame carries no format change and no result |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| di | output | 1 | Serial data to converter |
| do_in | input | 1 | Serial data from converter |
| result | output | 17 | Extended signed result |
| result_valid | output | 1 | End-of-frame pulse |
| exp_len | output | 5 | Pulse count the converter expects next |

## Verification
The hardest case is a frame whose pulse count, bit order and extension all come from the frame before it. A wrong implementation can still look correct on a single frame. The stimulus therefore chains frames so that every change in resolution, sign and order is followed by a frame that depends on it. It alternates between CS modes, and it places instruction-only frames between format changes so that an accidental commit or result update becomes visible. A converter model in the bench counts the SCLK edges and serves each word in the order the bench expects.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int WMAX = 17;
  localparam logic [1:0] RES_8  = 2'd0;
  localparam logic [1:0] RES_12 = 2'd1;
  localparam logic [1:0] RES_16 = 2'd2;

  // word length expected by the converter for a given format
  function automatic logic [4:0] frame_len(logic [1:0] res, logic sgn);
    logic [4:0] base;
    case (res)
      RES_8:   base = 5'd8;
      RES_16:  base = 5'd16;
      default: base = 5'd12;
    endcase
    return base + {4'd0, sgn};
  endfunction

  // widen a len-bit word to WMAX bits, signed or unsigned
  function automatic logic [WMAX-1:0] widen(logic [WMAX-1:0] raw, logic [4:0] len, logic sgn);
    logic [WMAX-1:0] o;
    logic top;
    top = raw[len - 5'd1];
    for (int i = 0; i < WMAX; i++) begin
      if (5'(i) < len) o[i] = raw[i];
      else             o[i] = sgn & top;
    end
    return o;
  endfunction
endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sadc_di_shift.sv
module sadc_di_shift #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] instr,
  input  logic          shift,
  output logic          di
);
  logic [IW-1:0] sr;
  assign di = sr[IW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= instr;
    else if (shift) sr <= {sr[IW-2:0], 1'b0};
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         smp,
  input  logic         d,
  input  logic         lsb,
  input  logic [4:0]   idx,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (clr) word <= '0;
    else if (smp) begin
      if (lsb) word[idx] <= d;
      else     word <= {word[W-2:0], d};
    end
  end
endmodule

// File: rtl/sadc_frame_master.sv
module sadc_frame_master
  import sadc_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int IW        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IW-1:0]     req_instr,
  input  logic [1:0]        req_res,
  input  logic              req_sign,
  input  logic              req_lsb_first,
  input  logic              req_cs_strobed,
  input  logic              req_instr_only,
  output logic              sclk,
  output logic              cs_n,
  output logic              di,
  input  logic              do_in,
  output logic [WMAX-1:0]   result,
  output logic              result_valid,
  output logic [4:0]        exp_len
);
  localparam int GAP = 2 * SCLK_HALF;
  localparam int GW  = $clog2(GAP + 1);

  logic          busy, tick, accept, rise_ev, fall_ev, last_fall;
  logic [4:0]    rise_cnt, target;
  logic [GW-1:0] gap_cnt;
  logic [1:0]    res_c, res_n;
  logic          sign_c, lsb_c, sign_n, lsb_n, strobe_n, ionly_n;
  logic [WMAX-1:0] cap_word;

  assign exp_len   = frame_len(res_c, sign_c);
  assign req_ready = !busy && (gap_cnt == '0);
  assign accept    = req_valid && req_ready;
  assign rise_ev   = busy && tick && !sclk;
  assign fall_ev   = busy && tick && sclk;
  assign last_fall = fall_ev && (rise_cnt == target);

  sadc_clkgen #(.HALF(SCLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick));

  sadc_di_shift #(.IW(IW)) u_di (
    .clk(clk), .rst_n(rst_n), .load(accept), .instr(req_instr),
    .shift(fall_ev), .di(di));

  sadc_capture #(.W(WMAX)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .smp(rise_ev), .d(do_in),
    .lsb(lsb_c), .idx(rise_cnt), .word(cap_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
      rise_cnt <= '0; target <= '0; gap_cnt <= '0;
      res_c <= RES_12; sign_c <= 1'b1; lsb_c <= 1'b0;
      res_n <= RES_12; sign_n <= 1'b0; lsb_n <= 1'b0;
      strobe_n <= 1'b0; ionly_n <= 1'b0;
      result <= '0; result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - GW'(1);
      if (accept) begin
        busy     <= 1'b1;
        cs_n     <= 1'b0;
        rise_cnt <= '0;
        target   <= (req_cs_strobed && req_instr_only) ? 5'(IW) : exp_len;
        res_n    <= req_res;
        sign_n   <= req_sign;
        lsb_n    <= req_lsb_first;
        strobe_n <= req_cs_strobed;
        ionly_n  <= req_instr_only;
      end
      if (rise_ev) begin
        sclk     <= 1'b1;
        rise_cnt <= rise_cnt + 5'd1;
      end
      if (fall_ev) sclk <= 1'b0;
      if (last_fall) begin
        busy         <= 1'b0;
        result_valid <= 1'b1;
        if (strobe_n) begin
          cs_n    <= 1'b1;
          gap_cnt <= GW'(GAP);
        end
        if (!ionly_n) begin
          result <= widen(cap_word, exp_len, sign_c);
          res_c  <= res_n;
          sign_c <= sign_n;
          lsb_c  <= lsb_n;
        end
      end
    end
  end

  // assertions next to the logic they guard
  a_r10_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r3_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(exp_len));
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rise_cnt <= target));
  a_r4_cs_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);
  a_r6_gap_holds_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt != '0) |-> (cs_n && !req_ready));
  a_r7_di_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_ev)) |-> $stable(di));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exp_len inside {5'd8, 5'd9, 5'd12, 5'd13, 5'd16, 5'd17});
endmodule

// File: tb/sadc_frame_master_bench.sv
module sadc_frame_master_bench;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_instr = '0;
  logic [1:0] req_res = '0;
  logic req_sign = 1'b0, req_lsb_first = 1'b0, req_cs_strobed = 1'b0, req_instr_only = 1'b0;
  logic sclk, cs_n, di, do_in, result_valid;
  logic [16:0] result;
  logic [4:0] exp_len;

  always #2 clk = ~clk;

  sadc_frame_master #(.SCLK_HALF(HALF), .IW(8)) u_sadc_frame_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_res(req_res), .req_sign(req_sign),
    .req_lsb_first(req_lsb_first), .req_cs_strobed(req_cs_strobed),
    .req_instr_only(req_instr_only), .sclk(sclk), .cs_n(cs_n), .di(di),
    .do_in(do_in), .result(result), .result_valid(result_valid), .exp_len(exp_len));

  typedef struct {
    int          cnt;
    logic [7:0]  instr;
    int          new_len;
    logic        upd;
    logic [16:0] res;
    logic        strobed;
  } exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0, frames_seen = 0;
  int k = 0;
  logic [7:0] di_cap = '0;
  logic [16:0] cur_word = '0;
  int cur_len = 13;
  logic cur_sign = 1'b1, cur_lsb = 1'b0;
  logic [16:0] last_res = '0;

  // converter model: next DO bit chosen from the rising-edge count
  assign do_in = (k < cur_len) ? (cur_lsb ? cur_word[k] : cur_word[cur_len-1-k]) : 1'b0;

  always @(posedge sclk) begin
    if (k < 8) di_cap[7-k] = di;
    k = k + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (q.size() == 0) begin
        check("R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.strobed && e.cnt == 8 ? "R5 pulse count" : "R4 pulse count", k, e.cnt);
        check("R7 instruction on DI", {24'd0, di_cap}, {24'd0, e.instr});
        check("R3 committed length", {27'd0, exp_len}, e.new_len);
        check("R8 R9 result", {15'd0, result}, {15'd0, e.res});
        if (e.strobed) begin
          check("R6 cs high at end", {31'd0, cs_n}, 1);
          check("R6 ready held low", {31'd0, req_ready}, 0);
        end else begin
          check("R4 cs stays low", {31'd0, cs_n}, 0);
        end
      end
      frames_seen++;
    end
  end

  function automatic int len_of(logic [1:0] r, logic s);
    int b;
    b = (r == 2'd0) ? 8 : (r == 2'd2) ? 16 : 12;
    return b + (s ? 1 : 0);
  endfunction

  // driver: computes expectations, pushes them, then issues the request
  task automatic frame(input logic [7:0] ins, input logic [1:0] r, input logic s,
                       input logic lsb, input logic strb, input logic io,
                       input logic [16:0] w);
    exp_t e;
    logic [16:0] t;
    int sh, target;
    target = frames_seen + 1;
    sh = 17 - cur_len;
    t = w << sh;
    e.cnt = (strb && io) ? 8 : cur_len;
    e.instr = ins;
    e.upd = !io;
    e.strobed = strb;
    if (!io) begin
      e.res = cur_sign ? 17'($signed(t) >>> sh) : (t >> sh);
      e.new_len = len_of(r, s);
    end else begin
      e.res = last_res;
      e.new_len = cur_len;
    end
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_word = w; k = 0; di_cap = '0;
    req_instr = ins; req_res = r; req_sign = s; req_lsb_first = lsb;
    req_cs_strobed = strb; req_instr_only = io; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 ready low in frame", {31'd0, req_ready}, 0);
    wait (frames_seen == target);
    if (!io) begin
      last_res = e.res;
      cur_len = len_of(r, s);
      cur_sign = s;
      cur_lsb = lsb;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset length", {27'd0, exp_len}, 13);
    check("R1 reset cs", {31'd0, cs_n}, 1);
    check("R1 reset sclk", {31'd0, sclk}, 0);
    check("R1 reset ready", {31'd0, req_ready}, 1);
    check("R1 reset done", {31'd0, result_valid}, 0);
    // R5: strobed instruction-only frame, 8 pulses, no commit
    frame(8'hA5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 17'h0);
    // R9: 13-bit signed MSB-first word, commit 8-bit unsigned
    frame(8'h3C, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 17'h1A5C);
    // R4: continuous, 8-bit word, commit 12-bit LSB-first
    frame(8'h81, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 17'h00C3);
    // R4 R5: continuous instruction-only frame keeps full length
    frame(8'h5A, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 17'h0);
    // R8: 12-bit LSB-first, commit 16-bit signed LSB-first
    frame(8'hF0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 17'h0ABC);
    // R8 R9: 17-bit LSB-first negative, commit 8-bit signed MSB-first
    frame(8'h0F, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h18001);
    // R2: code 3 behaves as 12 bits
    frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 17'h01F0);
    frame(8'h99, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 17'h0);
    frame(8'h66, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 17'h0800);
    frame(8'h12, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 17'hFFFF);
    frame(8'hE7, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 17'h00A5);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule